// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of octets into the bit stream of one HDLC channel. Octets arrive on a ready/valid input that marks the first and last octet of each frame. The block sends one line bit on each clock cycle where the gapped bit enable is high. Between frames it repeats a programmable flag octet. Inside a frame it sends the data, then a CRC-16 or CRC-32 frame check sequence chosen at run time, then a closing flag. In the data and FCS it inserts a zero after every five consecutive ones.

A frame can be cut short in two ways. The host can request an abort, or the input can run dry before the end-of-frame marker arrives. In both cases the block sends eight ones at the next octet boundary and then returns to flag fill. A dry input also raises a one-cycle underrun pulse. A transparent mode sends each octet unchanged, with no framing. A 56 kbit/s slot format reserves every eighth line bit and drives it high.

The control path is a four-state machine:
- FILL: sends flags, or transparent octets when that mode is on.
- BODY: sends frame data.
- FCS: sends the check sequence bytes.
- ABORT: sends one all-ones octet.

It changes state only at an octet boundary, meaning the enabled cycle that sends bit 7 of the current octet:
- FILL→BODY when an octet marked as a frame start is taken.
- BODY→FCS after the octet marked as frame end.
- BODY→ABORT on a pending abort or on underflow.
- FCS→FILL after the last FCS byte.
- FCS→ABORT on a pending abort.
- ABORT→FILL always.

Reset enters ABORT.

Top module: `hdlc_tx`

## Requirements
- R1: During and right after reset, tx_bit is 1 and in_ready is 0. The first eight line bits after reset are all ones, and the line then carries flags.
- R2: While no frame is active, the octet on cfg_flag is sent over and over, least significant bit first, with no zero insertion.
- R3: A frame is sent as the data octets, each least significant bit first, then the FCS, then a closing flag. This sequence follows the flag during which its first octet is taken on the octet boundary.
- R4: Within the data and FCS bits, a 0 is inserted after every five consecutive ones. This includes a run that ends at the last FCS bit. Inserted bits do not enter the CRC.
- R5: With cfg_crc32=0, the FCS is 16 bits. It uses the reflected polynomial 0x8408, with the register preset to 0xFFFF. The complemented register is sent low byte first, each byte least significant bit first.
- R6: With cfg_crc32=1, the FCS is 32 bits. It uses the reflected polynomial 0xEDB88320, with the register preset to all ones. The complemented register is sent low byte first.
- R7: A one-cycle abort_req pulse during a frame makes the block do the following at the next octet boundary: take no more input, send 0xFF unstuffed, then send flags. underrun stays low.
- R8: If in_valid is low at an octet boundary in the middle of a frame, the block sends 0xFF and then flags. underrun is high for exactly one cycle.
- R9: With cfg_transp=1, every valid octet is sent unchanged, with no insertion and no FCS. Flags fill the line when no octet is offered.
- R10: With cfg_slot56=1, line bit 8k+7 is forced to 1, counting enabled cycles from reset. This bit carries no data and does not count toward zero insertion.
- R11: On a cycle with bit_en low, tx_bit holds its value and nothing advances.
- R12: While idle, an octet offered without in_sof is accepted and dropped. The line keeps sending flags.
- R13: in_ready is high only on an enabled cycle at an octet boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bit_en | input | 1 | gapped bit enable; one line bit per high cycle |
| cfg_flag | input | 8 | flag octet used for fill |
| cfg_crc32 | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| cfg_transp | input | 1 | transparent octet mode |
| cfg_slot56 | input | 1 | 56 kbit/s slot format |
| abort_req | input | 1 | host abort request pulse |
| in_valid | input | 1 | octet offered |
| in_data | input | 8 | octet value |
| in_sof | input | 1 | octet starts a frame |
| in_eof | input | 1 | octet ends a frame |
| in_ready | output | 1 | octet taken this cycle when in_valid is high |
| tx_bit | output | 1 | serial line bit |
| underrun | output | 1 | one-cycle pulse on underflow abort |

## Verification
The assertions take the configuration inputs to be static while the block runs. The stimulus sets them only while reset is held. The assertions also assume that abort_req is a short pulse and that an abort leaves no stale frame octets at the input. The bench therefore stops offering data the moment it raises an abort. The bench drives every input at the falling edge, samples in_ready at that point to decide what was taken, and predicts the whole line stream from its own CRC and insertion model.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int OCT_W = 8;
    localparam int CRC_W = 32;
    localparam logic [15:0]      POLY16 = 16'h8408;
    localparam logic [CRC_W-1:0] POLY32 = 32'hEDB88320;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FCS   = 2'd2,
        ST_ABORT = 2'd3
    } tx_state_t;
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             din,
    input  logic             wide,
    output logic [CRC_W-1:0] crc_nxt
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    assign fb = crc_q[0] ^ din;

    always_comb begin
        crc_nxt = crc_q;
        if (init) begin
            crc_nxt = wide ? {CRC_W{1'b1}} : {{(CRC_W-16){1'b0}}, 16'hFFFF};
        end else if (step) begin
            if (wide) crc_nxt = (crc_q >> 1) ^ (fb ? POLY32 : {CRC_W{1'b0}});
            else      crc_nxt = {{(CRC_W-15){1'b0}}, crc_q[15:1]}
                                ^ {{(CRC_W-16){1'b0}}, (fb ? POLY16 : 16'h0000)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= {CRC_W{1'b1}};
        else        crc_q <= crc_nxt;
    end

    // R5
    crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q[15:0] == 16'hFFFF));
endmodule

// File: rtl/hdlc_tx_slot.sv
module hdlc_tx_slot #(
    parameter int SLOT_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic slot56,
    output logic pad,
    output logic pay_en
);
    localparam int PW = $clog2(SLOT_BITS);
    localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pos_q <= '0;
        else if (bit_en) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    assign pad    = slot56 && (pos_q == LAST);
    assign pay_en = bit_en && !pad;

    // R10
    pad_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad && bit_en) |=> !pad);
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int SLOT_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [OCT_W-1:0] cfg_flag,
    input  logic             cfg_crc32,
    input  logic             cfg_transp,
    input  logic             cfg_slot56,
    input  logic             abort_req,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             in_ready,
    output logic             tx_bit,
    output logic             underrun
);
    localparam int BW = $clog2(OCT_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(OCT_W - 1);

    tx_state_t        state_q, state_d;
    logic [OCT_W-1:0] sh_q, load_val;
    logic [BW-1:0]    cnt_q;
    logic [2:0]       ones_q;
    logic [1:0]       idx_q, idx_d, last_idx;
    logic             last_q, last_d, abort_q, abort_d;
    logic             tx_q, ur_q, uflow, crc_init;
    logic             pad, pay_en, stuff_now, shift_now, boundary, stuffable;
    logic [CRC_W-1:0] crc_nxt;

    hdlc_tx_slot #(.SLOT_BITS(SLOT_BITS)) u_slot (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot56(cfg_slot56),
        .pad(pad), .pay_en(pay_en)
    );

    hdlc_tx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .init(crc_init),
        .step(shift_now && state_q == ST_BODY), .din(sh_q[0]),
        .wide(cfg_crc32), .crc_nxt(crc_nxt)
    );

    assign stuffable = (state_q == ST_BODY) || (state_q == ST_FCS);
    assign stuff_now = pay_en && (ones_q == 3'd5);
    assign shift_now = pay_en && !stuff_now;
    assign boundary  = shift_now && (cnt_q == LAST_BIT);
    assign last_idx  = cfg_crc32 ? 2'd3 : 2'd1;

    // next state and octet selection
    always_comb begin
        state_d  = state_q;
        load_val = sh_q;
        last_d   = last_q;
        idx_d    = idx_q;
        uflow    = 1'b0;
        crc_init = 1'b0;
        in_ready = 1'b0;
        if (boundary) begin
            unique case (state_q)
                ST_FILL: begin
                    in_ready = 1'b1;
                    load_val = cfg_flag;
                    if (in_valid && cfg_transp) begin
                        load_val = in_data;
                    end else if (in_valid && in_sof) begin
                        load_val = in_data;
                        state_d  = ST_BODY;
                        crc_init = 1'b1;
                        last_d   = in_eof;
                    end
                end
                ST_BODY: begin
                    if (abort_q) begin
                        state_d  = ST_ABORT;
                        load_val = '1;
                    end else if (last_q) begin
                        state_d  = ST_FCS;
                        idx_d    = 2'd0;
                        load_val = ~crc_nxt[7:0];
                    end else begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            load_val = in_data;
                            last_d   = in_eof;
                        end else begin
                            state_d  = ST_ABORT;
                            load_val = '1;
                            uflow    = 1'b1;
                        end
                    end
                end
                ST_FCS: begin
                    if (abort_q) begin
                        state_d  = ST_ABORT;
                        load_val = '1;
                    end else if (idx_q == last_idx) begin
                        state_d  = ST_FILL;
                        load_val = cfg_flag;
                    end else begin
                        idx_d    = idx_q + 2'd1;
                        load_val = ~crc_nxt[{idx_d, 3'b000} +: 8];
                    end
                end
                ST_ABORT: begin
                    state_d  = ST_FILL;
                    load_val = cfg_flag;
                end
            endcase
        end
        abort_d = abort_q;
        if (state_d == ST_FILL || state_d == ST_ABORT) abort_d = 1'b0;
        else if (abort_req)                             abort_d = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ABORT;
        else        state_q <= state_d;
    end

    // octet shifter, counters, frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '1;
            cnt_q   <= '0;
            ones_q  <= 3'd0;
            last_q  <= 1'b0;
            idx_q   <= 2'd0;
            abort_q <= 1'b0;
        end else begin
            last_q  <= last_d;
            idx_q   <= idx_d;
            abort_q <= abort_d;
            if (stuff_now)      ones_q <= 3'd0;
            else if (shift_now) ones_q <= (stuffable && sh_q[0]) ? ones_q + 3'd1 : 3'd0;
            if (boundary)       sh_q <= load_val;
            else if (shift_now) sh_q <= {1'b1, sh_q[OCT_W-1:1]};
            if (shift_now)      cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= 1'b1;
            ur_q <= 1'b0;
        end else begin
            ur_q <= uflow;
            if (bit_en) tx_q <= pad ? 1'b1 : (stuff_now ? 1'b0 : sh_q[0]);
        end
    end

    assign tx_bit   = tx_q;
    assign underrun = ur_q;

    // R4
    no_six_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= 3'd5);
    // R13
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);
    // R8
    underrun_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (state_q == ST_ABORT));
    // R11
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R10
    pad_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad && bit_en) |=> tx_bit);
endmodule

// File: tb/hdlc_tx_test.sv
`timescale 1ns/100ps
module hdlc_tx_test;
    logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic [7:0] cfg_flag = 8'h7E;
    logic       cfg_crc32 = 1'b0, cfg_transp = 1'b0, cfg_slot56 = 1'b0;
    logic       abort_req = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    wire        in_ready, tx_bit, underrun;

    hdlc_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_flag(cfg_flag),
        .cfg_crc32(cfg_crc32), .cfg_transp(cfg_transp), .cfg_slot56(cfg_slot56),
        .abort_req(abort_req), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
        .tx_bit(tx_bit), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    logic [7:0] fr [0:31];
    int   fr_n, ptr, abort_at, gap_mode, ur_cnt, gap_err, rdy_err, ones_m;
    bit   fr_sof, fr_eof;
    bit   cap[$];
    bit   exp_q[$];

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; abort_req = 1'b0;
        in_sof = 1'b0; in_eof = 1'b0;
        cap.delete(); exp_q.delete();
        ptr = 0; ur_cnt = 0; gap_err = 0; rdy_err = 0; ones_m = 0;
        abort_at = -1; gap_mode = 0; fr_sof = 1'b1; fr_eof = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(int n);
        bit en_prev = 1'b0, last_tx = 1'b1, cons = 1'b0, ab_done = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (en_prev) cap.push_back(tx_bit);
            else if (tx_bit !== last_tx) gap_err++;
            last_tx = tx_bit;
            if (underrun) ur_cnt++;
            if (cons) ptr++;
            abort_req = 1'b0;
            if (abort_at >= 0 && !ab_done && ptr == abort_at) begin
                abort_req = 1'b1; ab_done = 1'b1; fr_n = ptr;
            end
            bit_en   = (gap_mode == 0) ? 1'b1 : ((k % 3) != 0);
            in_valid = (ptr < fr_n);
            in_data  = (ptr < fr_n) ? fr[ptr] : 8'h00;
            in_sof   = fr_sof && (ptr == 0);
            in_eof   = fr_eof && (ptr == fr_n - 1);
            en_prev  = bit_en;
            #1;
            if (in_ready && !bit_en) rdy_err++;
            cons = in_valid && in_ready;
        end
    endtask

    task automatic put_oct(logic [7:0] v, bit stuff);
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(v[i]);
            if (stuff && v[i]) begin
                ones_m++;
                if (ones_m == 5) begin exp_q.push_back(1'b0); ones_m = 0; end
            end else ones_m = 0;
        end
    endtask

    function automatic logic [31:0] crc_of(int n, bit wide);
        logic [31:0] c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
        for (int j = 0; j < n; j++)
            for (int i = 0; i < 8; i++) begin
                bit fb = c[0] ^ fr[j][i];
                c = c >> 1;
                if (fb) c = c ^ (wide ? 32'hEDB88320 : 32'h00008408);
            end
        return ~c;
    endfunction

    task automatic put_frame(int n, bit wide);
        logic [31:0] f = crc_of(n, wide);
        for (int j = 0; j < n; j++) put_oct(fr[j], 1'b1);
        for (int b = 0; b < (wide ? 4 : 2); b++) put_oct(f[8*b +: 8], 1'b1);
    endtask

    task automatic put_flags(int n);
        for (int i = 0; i < n; i++) put_oct(cfg_flag, 1'b0);
    endtask

    task automatic pad56();
        bit tmp[$];
        int li = 0;
        foreach (exp_q[i]) begin
            if (li % 8 == 7) begin tmp.push_back(1'b1); li++; end
            tmp.push_back(exp_q[i]); li++;
        end
        exp_q = tmp;
    endtask

    task automatic cmp(string req);
        int bad = -1;
        chk(cap.size() >= exp_q.size(), req, "captured bit count", cap.size(), exp_q.size());
        foreach (exp_q[i])
            if (bad < 0 && i < cap.size() && cap[i] != exp_q[i]) bad = i;
        chk(bad < 0, req, "line stream first mismatch index", bad, -1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx_bit === 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
        chk(in_ready === 1'b0, "R1", "in_ready in reset", in_ready, 0);
    endtask

    task automatic t_idle();
        cfg_flag = 8'h66; reset_dut(); fr_n = 0;
        run(300);
        put_oct(8'hFF, 1'b0); put_flags(20);
        cmp("R1 R2 idle");
        cfg_flag = 8'h7E;
    endtask

    task automatic t_crc16();
        reset_dut(); cfg_crc32 = 1'b0;
        fr[0] = 8'h01; fr[1] = 8'hFF; fr[2] = 8'hF8; fr[3] = 8'h3E;
        fr[4] = 8'h7C; fr[5] = 8'hA5; fr_n = 6;
        run(600);
        put_oct(8'hFF, 1'b0); put_flags(1); put_frame(6, 1'b0); put_flags(6);
        cmp("R3 R4 R5");
        chk(ptr == 6, "R3", "octets taken", ptr, 6);
        chk(ur_cnt == 0, "R3", "underrun pulses", ur_cnt, 0);
    endtask

    task automatic t_crc32();
        reset_dut(); cfg_crc32 = 1'b1; gap_mode = 1;
        fr[0] = 8'h12; fr[1] = 8'h9F; fr[2] = 8'hFF; fr[3] = 8'h00; fr[4] = 8'hC3; fr_n = 5;
        run(900);
        put_oct(8'hFF, 1'b0); put_flags(1); put_frame(5, 1'b1); put_flags(6);
        cmp("R6 R11");
        chk(gap_err == 0, "R11", "tx_bit changes on idle cycles", gap_err, 0);
        chk(rdy_err == 0, "R13", "in_ready without bit_en", rdy_err, 0);
        cfg_crc32 = 1'b0;
    endtask

    task automatic t_abort();
        reset_dut();
        fr[0] = 8'h55; fr[1] = 8'h0F; fr[2] = 8'h33; fr[3] = 8'h44; fr_n = 4;
        abort_at = 2;
        run(400);
        put_oct(8'hFF, 1'b0); put_flags(1);
        put_oct(8'h55, 1'b1); put_oct(8'h0F, 1'b1);
        put_oct(8'hFF, 1'b0); put_flags(6);
        cmp("R7");
        chk(ur_cnt == 0, "R7", "underrun pulses on host abort", ur_cnt, 0);
        chk(ptr == 2, "R7", "octets taken", ptr, 2);
    endtask

    task automatic t_uflow();
        reset_dut(); fr_eof = 1'b0;
        fr[0] = 8'hA1; fr[1] = 8'h7F; fr[2] = 8'h3C; fr_n = 3;
        run(400);
        put_oct(8'hFF, 1'b0); put_flags(1);
        for (int j = 0; j < 3; j++) put_oct(fr[j], 1'b1);
        put_oct(8'hFF, 1'b0); put_flags(6);
        cmp("R8");
        chk(ur_cnt == 1, "R8", "underrun pulses", ur_cnt, 1);
    endtask

    task automatic t_transp();
        reset_dut(); cfg_transp = 1'b1;
        fr[0] = 8'hFF; fr[1] = 8'hFF; fr[2] = 8'h7E; fr[3] = 8'h81; fr_n = 4;
        run(400);
        put_oct(8'hFF, 1'b0); put_flags(1);
        for (int j = 0; j < 4; j++) put_oct(fr[j], 1'b0);
        put_flags(6);
        cmp("R9");
        cfg_transp = 1'b0;
    endtask

    task automatic t_slot56();
        reset_dut(); cfg_slot56 = 1'b1;
        fr[0] = 8'hFE; fr[1] = 8'hFF; fr[2] = 8'h07; fr_n = 3;
        run(600);
        put_oct(8'hFF, 1'b0); put_flags(1); put_frame(3, 1'b0); put_flags(6);
        pad56();
        cmp("R10");
        cfg_slot56 = 1'b0;
    endtask

    task automatic t_discard();
        reset_dut(); fr_sof = 1'b0;
        fr[0] = 8'h00; fr_n = 1;
        run(300);
        put_oct(8'hFF, 1'b0); put_flags(20);
        cmp("R12");
        chk(ptr == 1, "R12", "stray octet accepted", ptr, 1);
    endtask

    initial begin
        #500us;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_crc16();
        t_crc32();
        t_abort();
        t_uflow();
        t_transp();
        t_slot56();
        t_discard();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule